// File: doc/BRIEF.md
# Indirect Memory Access Port

This block gives a host on a simple synchronous register bus access to two private word memories, one holding instructions and one holding data, without mapping either memory into the bus address space. Each memory is reached through a pair of registers: a control register that holds a byte offset and two auto-increment enables, and a data register. A data-register write stores the bus word at the held offset. A data-register read returns the word at that offset. Either access can move the offset on by one word, so that a host can stream a whole image with one control write followed by a run of data accesses.

Two read-only configuration registers describe the memories. One gives each memory's size as a count of 256-byte blocks. The other gives the number of access ports per memory. The block claims a 0x300-byte window that starts at the parameter `BASE_ADDR`. The production setting of 127 KiB per memory is `IMEM_BLOCKS = DMEM_BLOCKS = 508`. The defaults are kept small.

Each access is decoded into one of the register selections `SEL_NONE`, `SEL_I_CTRL`, `SEL_I_DATA`, `SEL_D_CTRL`, `SEL_D_DATA`, `SEL_SIZE` and `SEL_PORTS`. The selection is recomputed on every cycle and carries no state between accesses. The only state is held in the two control registers and in the read-data register.

Top module: `imap_port`

## Requirements
- R1: `bus_hit` is high exactly when a strobe is active and `BASE_ADDR <= bus_addr < BASE_ADDR + 0x300`. A read outside that window returns `bus_rvalid` = 0 and `bus_rdata` = 0. A write outside that window changes no state.
- R2: The register offsets from `BASE_ADDR` are:
  - 0x180: instruction-memory control
  - 0x184: instruction-memory data
  - 0x1C0: data-memory control
  - 0x1C4: data-memory data
  - 0x108: size register
  - 0x12C: ports register

  Any other offset inside the window reads as 0 and ignores writes. The configuration registers also ignore writes.
- R3: Control register layout:
  - bits [16:2]: the byte offset, made of the block number in [16:8] and the in-block offset in [7:2]
  - bits [1:0]: always read 0
  - bit 24: write auto-increment
  - bit 25: read auto-increment
  - bit 26: sticky error
  - all other bits read 0

  A control write loads these fields from the bus data. A control read returns the stored value, including any offset advances.
- R4: A data write with bit 24 set stores the 32-bit word at the offset and adds 4 to the offset, leaving the other control bits unchanged. With bit 24 clear, the write stores nothing and the offset does not move.
- R5: A data read with bit 25 set returns the word at the offset and adds 4 to the offset. With bit 25 clear, the read returns 0 and the offset does not move.
- R6: When the offset is at or beyond `BLOCKS*256` bytes, a data access with its increment bit set:
  - writes nothing to memory
  - reads 0
  - leaves the offset unchanged
  - sets bit 26

  Bit 26 stays set until the control register is written.
- R7: The two memories and their control registers are independent. An access to one never alters the other.
- R8: The size register holds the instruction-memory block count in bits [8:0] and the data-memory block count in bits [17:9]. All other bits read 0.
- R9: The ports register reads 1 in bits [11:8] (instruction-memory ports) and 1 in bits [15:12] (data-memory ports). All other bits read 0.
- R10: Read data and `bus_rvalid` appear one cycle after a claimed read strobe. Data accesses on consecutive cycles each use the offset left by the previous access. Read and write strobes are never high together.
- R11: After reset, both control registers read 0, and `bus_rvalid` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| bus_rvalid | output | 1 | High one cycle after a claimed read |
| bus_hit | output | 1 | Current strobe falls inside the register window |

## Verification
The assertions check the following on every cycle:
- the control register holds still when no access targets it
- an in-range auto-incremented access advances the offset by exactly one word
- an out-of-range access sets the error bit without moving the offset, and the error bit stays set
- a data read without its increment bit returns zero
- the one-cycle read response and the mutual exclusion of the strobes hold

Only the bench's scenarios can show the following:
- stored words come back intact after full-memory streams
- the two memories stay independent
- the configuration fields are packed correctly
- mapped registers ignore writes from outside the window

// File: rtl/imap_pkg.sv
package imap_pkg;
    localparam int          BLOCK_BYTES = 256;
    localparam logic [31:0] WIN_BYTES   = 32'h0000_0300;

    localparam logic [9:0] OFS_I_CTRL = 10'h180;
    localparam logic [9:0] OFS_I_DATA = 10'h184;
    localparam logic [9:0] OFS_D_CTRL = 10'h1C0;
    localparam logic [9:0] OFS_D_DATA = 10'h1C4;
    localparam logic [9:0] OFS_SIZE   = 10'h108;
    localparam logic [9:0] OFS_PORTS  = 10'h12C;

    localparam int BIT_WINC = 24;
    localparam int BIT_RINC = 25;
    localparam int BIT_ERR  = 26;
    localparam logic [31:0] CTRL_MASK = 32'h0701_FFFC;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_I_CTRL,
        SEL_I_DATA,
        SEL_D_CTRL,
        SEL_D_DATA,
        SEL_SIZE,
        SEL_PORTS
    } reg_sel_e;
endpackage

// File: rtl/imap_decode.sv
module imap_decode
    import imap_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0001_0000
) (
    input  logic [31:0] addr,
    output logic        in_win,
    output reg_sel_e    sel
);
    logic [31:0] offs;

    assign offs   = addr - BASE_ADDR;
    assign in_win = (addr >= BASE_ADDR) && (offs < WIN_BYTES);

    always_comb begin
        sel = SEL_NONE;
        if (in_win) begin
            unique case (offs[9:0])
                OFS_I_CTRL: sel = SEL_I_CTRL;
                OFS_I_DATA: sel = SEL_I_DATA;
                OFS_D_CTRL: sel = SEL_D_CTRL;
                OFS_D_DATA: sel = SEL_D_DATA;
                OFS_SIZE:   sel = SEL_SIZE;
                OFS_PORTS:  sel = SEL_PORTS;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/imap_chan.sv
module imap_chan
    import imap_pkg::*;
#(
    parameter int BLOCKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic        data_we,
    input  logic        data_re,
    input  logic [31:0] wdata,
    output logic [31:0] ctrl_o,
    output logic [31:0] word_o
);
    localparam int          WORDS   = BLOCKS * BLOCK_BYTES / 4;
    localparam int          AW      = $clog2(WORDS);
    localparam logic [14:0] WORDS_L = 15'(WORDS);

    logic [31:0] ctrl_q;
    logic [31:0] word_q;
    logic [31:0] mem [WORDS];
    logic [14:0] widx;
    logic        wr_inc, rd_inc, in_range, acc_wr, acc_rd;

    assign widx     = ctrl_q[16:2];
    assign wr_inc   = ctrl_q[BIT_WINC];
    assign rd_inc   = ctrl_q[BIT_RINC];
    assign in_range = widx < WORDS_L;
    assign acc_wr   = data_we && wr_inc;
    assign acc_rd   = data_re && rd_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= wdata & CTRL_MASK;
        end else if (acc_wr || acc_rd) begin
            if (in_range) ctrl_q[16:2] <= widx + 15'd1;
            else          ctrl_q[BIT_ERR] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (acc_wr && in_range) mem[widx[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  word_q <= '0;
        else if (acc_rd && in_range) word_q <= mem[widx[AW-1:0]];
        else                         word_q <= '0;
    end

    assign ctrl_o = ctrl_q;
    assign word_o = word_q;

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && !data_we && !data_re) |=> $stable(ctrl_q));
    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_wr || acc_rd) && in_range && !ctrl_we) |=> (ctrl_q[16:2] == 15'($past(widx) + 15'd1)));
    p_oob_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_wr || acc_rd) && !in_range && !ctrl_we) |=> (ctrl_q[BIT_ERR] && ctrl_q[16:2] == $past(widx)));
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[BIT_ERR] && !ctrl_we) |=> ctrl_q[BIT_ERR]);
    p_rd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && !rd_inc) |=> (word_q == 32'h0));
endmodule

// File: rtl/imap_port.sv
module imap_port
    import imap_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0001_0000,
    parameter int          IMEM_BLOCKS = 4,
    parameter int          DMEM_BLOCKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    output logic        bus_hit
);
    localparam logic [31:0] SIZE_VAL  = {14'd0, 9'(DMEM_BLOCKS), 9'(IMEM_BLOCKS)};
    localparam logic [31:0] PORTS_VAL = 32'h0000_1100;

    logic        in_win;
    reg_sel_e    sel;
    logic [31:0] ctrl_v [2];
    logic [31:0] word_v [2];
    logic [31:0] csr_val;
    logic [31:0] rdata_q;
    logic        rvalid_q;

    imap_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .addr   (bus_addr),
        .in_win (in_win),
        .sel    (sel)
    );

    for (genvar g = 0; g < 2; g++) begin : g_chan
        localparam int       BLKS  = (g == 0) ? IMEM_BLOCKS : DMEM_BLOCKS;
        localparam reg_sel_e CSEL  = (g == 0) ? SEL_I_CTRL : SEL_D_CTRL;
        localparam reg_sel_e DSEL  = (g == 0) ? SEL_I_DATA : SEL_D_DATA;
        imap_chan #(.BLOCKS(BLKS)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (bus_wr && (sel == CSEL)),
            .data_we (bus_wr && (sel == DSEL)),
            .data_re (bus_rd && (sel == DSEL)),
            .wdata   (bus_wdata),
            .ctrl_o  (ctrl_v[g]),
            .word_o  (word_v[g])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_I_CTRL: csr_val = ctrl_v[0];
            SEL_D_CTRL: csr_val = ctrl_v[1];
            SEL_SIZE:   csr_val = SIZE_VAL;
            SEL_PORTS:  csr_val = PORTS_VAL;
            default:    csr_val = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd && in_win;
            rdata_q  <= (bus_rd && in_win) ? csr_val : 32'h0;
        end
    end

    assign bus_hit    = in_win && (bus_rd || bus_wr);
    assign bus_rvalid = rvalid_q;
    assign bus_rdata  = rdata_q | word_v[0] | word_v[1];

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_rvalid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_hit) |=> bus_rvalid);
    p_unclaimed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_hit) |=> (!bus_rvalid && bus_rdata == 32'h0));
endmodule

// File: tb/imap_port_tb_top.sv
module imap_port_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE  = 32'h0001_0000;
    localparam int          IBLK  = 4;
    localparam int          DBLK  = 3;
    localparam int          IWORDS = IBLK * 64;
    localparam int          DWORDS = DBLK * 64;
    localparam logic [31:0] A_IC = BASE + 32'h180;
    localparam logic [31:0] A_ID = BASE + 32'h184;
    localparam logic [31:0] A_DC = BASE + 32'h1C0;
    localparam logic [31:0] A_DD = BASE + 32'h1C4;
    localparam logic [31:0] A_SZ = BASE + 32'h108;
    localparam logic [31:0] A_PT = BASE + 32'h12C;
    localparam logic [31:0] WINC = 32'h0100_0000;
    localparam logic [31:0] RINC = 32'h0200_0000;
    localparam logic [31:0] ERRB = 32'h0400_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        bus_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    imap_port #(.BASE_ADDR(BASE), .IMEM_BLOCKS(IBLK), .DMEM_BLOCKS(DBLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_hit(bus_hit)
    );

    function automatic logic [31:0] ipat(int i);
        return 32'hA000_0000 | 32'(i * 7);
    endfunction
    function automatic logic [31:0] dpat(int i);
        return 32'h5000_0000 | 32'(i * 13);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [31:0] a, output logic [31:0] d, output logic v, output logic h);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 h = bus_hit;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic fill(logic [31:0] a, int n, bit is_i);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_addr = a; bus_wr = 1'b1;
            bus_wdata = is_i ? ipat(i) : dpat(i);
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic drain(logic [31:0] a, int n, bit is_i, string req);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check(req, bus_rdata, is_i ? ipat(i-1) : dpat(i-1));
                check(req, 32'(bus_rvalid), 32'h1);
            end
            bus_addr = a;
            bus_rd = (i < n);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
                summary();
            end
        end
    end

    initial begin
        logic [31:0] d;
        logic v, h;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 rvalid", 32'(bus_rvalid), 32'h0);
        check("R11 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        rd(A_IC, d, v, h); check("R11 ictrl", d, 32'h0);
        rd(A_DC, d, v, h); check("R11 dctrl", d, 32'h0);

        // R8, R9 configuration registers
        rd(A_SZ, d, v, h); check("R8 size", d, 32'(IBLK) | (32'(DBLK) << 9));
        rd(A_PT, d, v, h); check("R9 ports", d, (32'h1 << 8) | (32'h1 << 12));
        wr(A_SZ, 32'hFFFF_FFFF);
        rd(A_SZ, d, v, h); check("R2 size ignores write", d, 32'(IBLK) | (32'(DBLK) << 9));

        // R4, R10 full back-to-back fills
        wr(A_IC, WINC);
        fill(A_ID, IWORDS, 1'b1);
        rd(A_IC, d, v, h); check("R4 ictrl after fill", d, WINC | 32'(IWORDS * 4));
        wr(A_DC, WINC);
        fill(A_DD, DWORDS, 1'b0);
        rd(A_DC, d, v, h); check("R4 dctrl after fill", d, WINC | 32'(DWORDS * 4));
        // R6 write past end
        wr(A_ID, 32'h1234_5678);
        rd(A_IC, d, v, h); check("R6 oob write err", d, WINC | ERRB | 32'(IWORDS * 4));
        rd(A_DC, d, v, h); check("R7 dctrl untouched", d, WINC | 32'(DWORDS * 4));

        // R5, R10, R7 back-to-back read streams
        wr(A_IC, RINC);
        drain(A_ID, IWORDS, 1'b1, "R5 imem stream");
        rd(A_IC, d, v, h); check("R5 ictrl after drain", d, RINC | 32'(IWORDS * 4));
        rd(A_ID, d, v, h); check("R6 oob read zero", d, 32'h0);
        rd(A_IC, d, v, h); check("R6 oob read err", d, RINC | ERRB | 32'(IWORDS * 4));
        rd(A_IC, d, v, h); check("R6 err sticky", d, RINC | ERRB | 32'(IWORDS * 4));
        wr(A_DC, RINC);
        drain(A_DD, DWORDS, 1'b0, "R7 dmem stream");

        // R4 write without increment is ignored
        wr(A_IC, 32'h10);
        wr(A_ID, 32'hDEAD_BEEF);
        rd(A_IC, d, v, h); check("R4 no-inc offset", d, 32'h10);
        wr(A_IC, RINC | 32'h10);
        rd(A_ID, d, v, h); check("R4 no-inc data kept", d, ipat(4));
        rd(A_IC, d, v, h); check("R5 advance", d, RINC | 32'h14);

        // R5 read without increment
        wr(A_IC, WINC | 32'h20);
        rd(A_ID, d, v, h); check("R5 no-inc zero", d, 32'h0);
        check("R5 no-inc valid", 32'(v), 32'h1);
        rd(A_IC, d, v, h); check("R5 no-inc offset", d, WINC | 32'h20);

        // R4 across a block boundary
        wr(A_IC, WINC | 32'hFC);
        wr(A_ID, 32'h0BAD_F00D);
        wr(A_ID, 32'hCAFE_0001);
        rd(A_IC, d, v, h); check("R4 block cross", d, WINC | 32'h104);
        wr(A_IC, RINC | 32'hFC);
        rd(A_ID, d, v, h); check("R4 word fc", d, 32'h0BAD_F00D);
        rd(A_ID, d, v, h); check("R4 word 100", d, 32'hCAFE_0001);

        // R3 field mask, error clear by write
        wr(A_IC, 32'hFFFF_FFFF);
        rd(A_IC, d, v, h); check("R3 mask", d, 32'h0701_FFFC);
        wr(A_ID, 32'h0);
        rd(A_IC, d, v, h); check("R6 oob no move", d, 32'h0701_FFFC);
        wr(A_IC, 32'h0);
        rd(A_IC, d, v, h); check("R3 clear", d, 32'h0);

        // R1, R2 window decode
        rd(BASE, d, v, h);
        check("R2 unmapped data", d, 32'h0);
        check("R1 unmapped valid", 32'(v), 32'h1);
        check("R1 unmapped hit", 32'(h), 32'h1);
        rd(BASE + 32'h300, d, v, h);
        check("R1 above valid", 32'(v), 32'h0);
        check("R1 above data", d, 32'h0);
        check("R1 above hit", 32'(h), 32'h0);
        rd(BASE - 32'h4, d, v, h);
        check("R1 below hit", 32'(h), 32'h0);
        wr(BASE + 32'h300 + 32'h180, 32'h44);
        wr(BASE, 32'h48);
        rd(A_IC, d, v, h); check("R1 alias write ignored", d, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule